// File: doc/BRIEF.md
# Clock-Gating Opportunity Monitor

The monitor watches a cluster of state registers that share one clock source and measures how often the whole cluster could have had its clock switched off. For every register it compares the value about to be loaded (the D bus slice) with the value already held (the Q bus slice). When the two are equal, loading is pointless and that register could skip the sample. The cluster as a whole can skip the sample only when every member can skip it. A per-member mask removes chosen registers from that aggregate decision; a masked register counts as always skippable.

Software or a test sequencer starts a window with a sample count N between 1 and 65536. Each cycle with the sample strobe high inside the window counts as one sample. The block keeps a running count of gatable samples for each register and one count for the aggregate. After the N-th sample it pulses done and freezes the counts. A bank of sequential dividers then turns every count into a fixed-point ratio count·2^FRAC_W/N. Ratio-valid rises when that result is ready. A new start during a window throws away the partial result and begins again.

Top module: `gate_opp_monitor`

## Requirements
- R1: A register's condition is 1 in a sample when all DATA_W bits of its D slice equal its Q slice. On each accepted sample its count (reg_cnt_o slice r, bits r·CNT_W upward) grows by that condition.
- R2: The aggregate condition is the AND over registers of (condition OR mask_i[r]). agg_cnt_o grows by it on each accepted sample, so agg_cnt_o never exceeds the count of any unmasked register.
- R3: start_i with n_i in 1..65536 clears all counts and ratio_valid_o and opens a window (busy_o high on the next cycle). A sample strobe in that same cycle is not counted. A start with n_i of 0 or above 65536 is ignored.
- R4: A sample is accepted only while busy_o is high and sample_i is high. After exactly N accepted samples busy_o falls. After reset busy_o, done_o, ratio_valid_o and all counts are 0.
- R5: done_o is high for exactly one cycle: the cycle after the clock edge that accepts the N-th sample. It is never high earlier in the window.
- R6: Outside a window the counts hold their values until the next valid start. Sample strobes have no effect on them.
- R7: Once the window closes, every ratio output becomes floor(count·2^FRAC_W/N) (FRAC_W = 8, so a count equal to N gives 256). ratio_valid_o then rises and stays high until the next valid start.
- R8: A valid start while a window is open discards the partial counts and restarts with the new N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Open (or restart) a window |
| n_i | input | CNT_W | Samples per window, taken at start |
| mask_i | input | NUM_REGS | 1 excludes a register from the aggregate AND |
| sample_i | input | 1 | Sample strobe |
| d_i | input | NUM_REGS·DATA_W | Next-state values, register r at bits r·DATA_W upward |
| q_i | input | NUM_REGS·DATA_W | Present-state values, same packing |
| busy_o | output | 1 | Window open |
| done_o | output | 1 | One-cycle pulse after the last sample |
| reg_cnt_o | output | NUM_REGS·CNT_W | Per-register gatable-sample counts |
| agg_cnt_o | output | CNT_W | Aggregate gatable-sample count |
| reg_ratio_o | output | NUM_REGS·(FRAC_W+1) | Per-register fixed-point ratios |
| agg_ratio_o | output | FRAC_W+1 | Aggregate fixed-point ratio |
| ratio_valid_o | output | 1 | Ratios ready |

## Verification
A wrong sample counter inside the window shows at the ports as done_o arriving a cycle early or late, or as busy_o staying high. It is caught at the first window that ends. A mis-formed condition or mask term shows up as a count mismatch at the end of that window. The aggregate-against-member property catches it on the very sample where the aggregate rises without an unmasked member. A faulty divider step only shows in the ratio outputs, some tens of cycles after done_o, when they are compared with the exact quotient.

// File: rtl/gom_pkg.sv
package gom_pkg;
  typedef enum logic [1:0] {DIV_IDLE, DIV_RUN, DIV_DONE} div_state_e;

  function automatic bit count_in_range(input int unsigned n, input int unsigned max_n);
    return (n != 0) && (n <= max_n);
  endfunction
endpackage

// File: rtl/gom_cond.sv
module gom_cond #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 8
) (
  input  logic [NUM_REGS*DATA_W-1:0] d_i,
  input  logic [NUM_REGS*DATA_W-1:0] q_i,
  input  logic [NUM_REGS-1:0]        mask_i,
  output logic [NUM_REGS-1:0]        reg_gate_o,
  output logic                       agg_gate_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    assign reg_gate_o[g] = &(d_i[g*DATA_W +: DATA_W] ~^ q_i[g*DATA_W +: DATA_W]);
  end

  // masked members never block the shared clock
  assign agg_gate_o = &(reg_gate_o | mask_i);
endmodule

// File: rtl/gom_window.sv
module gom_window import gom_pkg::*; #(
  parameter int MAX_N = 65536,
  parameter int CNT_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] n_i,
  input  logic             sample_i,
  output logic             clear_o,
  output logic             accept_o,
  output logic             active_o,
  output logic             done_o,
  output logic [CNT_W-1:0] n_q_o
);
  logic [CNT_W-1:0] seen_q;
  logic             last_sample;

  assign clear_o     = start_i && count_in_range(32'(n_i), MAX_N);
  assign accept_o    = active_o && sample_i && !clear_o;
  assign last_sample = (seen_q == n_q_o - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      done_o   <= 1'b0;
      seen_q   <= '0;
      n_q_o    <= CNT_W'(1);
    end else begin
      done_o <= 1'b0;
      if (clear_o) begin
        active_o <= 1'b1;
        seen_q   <= '0;
        n_q_o    <= n_i;
      end else if (accept_o) begin
        seen_q <= seen_q + CNT_W'(1);
        if (last_sample) begin
          active_o <= 1'b0;
          done_o   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/gom_divider.sv
module gom_divider import gom_pkg::*; #(
  parameter int CNT_W  = 17,
  parameter int FRAC_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic              abort_i,
  input  logic [CNT_W-1:0]  num_i,
  input  logic [CNT_W-1:0]  den_i,
  output logic [FRAC_W:0]   quo_o,
  output logic              valid_o
);
  localparam int RAT_W  = FRAC_W + 1;
  localparam int DVD_W  = CNT_W + FRAC_W;
  localparam int STEP_W = $clog2(DVD_W + 1);

  div_state_e        state_q;
  logic [DVD_W-1:0]  dvd_q;
  logic [CNT_W-1:0]  rem_q;
  logic [RAT_W-1:0]  quo_q;
  logic [STEP_W-1:0] steps_q;
  logic [CNT_W:0]    trial;
  logic              fits;
  logic [CNT_W-1:0]  rem_nxt;

  // restoring division, one quotient bit per cycle
  always_comb begin
    trial   = {rem_q, dvd_q[DVD_W-1]};
    fits    = (trial >= {1'b0, den_i});
    rem_nxt = fits ? CNT_W'(trial - {1'b0, den_i}) : trial[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= DIV_IDLE;
      dvd_q   <= '0;
      rem_q   <= '0;
      quo_q   <= '0;
      steps_q <= '0;
    end else if (abort_i) begin
      state_q <= DIV_IDLE;
    end else if (launch_i) begin
      state_q <= DIV_RUN;
      dvd_q   <= {num_i, {FRAC_W{1'b0}}};
      rem_q   <= '0;
      quo_q   <= '0;
      steps_q <= STEP_W'(DVD_W);
    end else if (state_q == DIV_RUN) begin
      dvd_q   <= dvd_q << 1;
      rem_q   <= rem_nxt;
      quo_q   <= {quo_q[RAT_W-2:0], fits};
      steps_q <= steps_q - STEP_W'(1);
      if (steps_q == STEP_W'(1)) state_q <= DIV_DONE;
    end
  end

  assign quo_o   = quo_q;
  assign valid_o = (state_q == DIV_DONE);
endmodule

// File: rtl/gate_opp_monitor.sv
module gate_opp_monitor import gom_pkg::*; #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 8,
  parameter int MAX_N    = 65536,
  parameter int FRAC_W   = 8,
  parameter int CNT_W    = $clog2(MAX_N + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic [CNT_W-1:0]             n_i,
  input  logic [NUM_REGS-1:0]          mask_i,
  input  logic                         sample_i,
  input  logic [NUM_REGS*DATA_W-1:0]   d_i,
  input  logic [NUM_REGS*DATA_W-1:0]   q_i,
  output logic                         busy_o,
  output logic                         done_o,
  output logic [NUM_REGS*CNT_W-1:0]    reg_cnt_o,
  output logic [CNT_W-1:0]             agg_cnt_o,
  output logic [NUM_REGS*(FRAC_W+1)-1:0] reg_ratio_o,
  output logic [FRAC_W:0]              agg_ratio_o,
  output logic                         ratio_valid_o
);
  localparam int NUM_CNT = NUM_REGS + 1;
  localparam int RAT_W   = FRAC_W + 1;

  logic [NUM_REGS-1:0] reg_gate;
  logic                agg_gate;
  logic                clear, accept;
  logic [CNT_W-1:0]    n_q;
  logic [NUM_CNT-1:0]  cnt_inc;
  logic [NUM_CNT-1:0]  div_valid;
  logic [CNT_W-1:0]    cnt_q   [NUM_CNT];
  logic [RAT_W-1:0]    ratio_w [NUM_CNT];

  gom_cond #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_cond (
    .d_i(d_i), .q_i(q_i), .mask_i(mask_i),
    .reg_gate_o(reg_gate), .agg_gate_o(agg_gate)
  );

  gom_window #(.MAX_N(MAX_N), .CNT_W(CNT_W)) u_window (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .n_i(n_i),
    .sample_i(sample_i), .clear_o(clear), .accept_o(accept),
    .active_o(busy_o), .done_o(done_o), .n_q_o(n_q)
  );

  // slot NUM_REGS holds the aggregate
  assign cnt_inc = {agg_gate, reg_gate};

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     cnt_q[g] <= '0;
      else if (clear)                  cnt_q[g] <= '0;
      else if (accept && cnt_inc[g])   cnt_q[g] <= cnt_q[g] + CNT_W'(1);
    end

    gom_divider #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_div (
      .clk_i(clk_i), .rst_ni(rst_ni), .launch_i(done_o), .abort_i(clear),
      .num_i(cnt_q[g]), .den_i(n_q), .quo_o(ratio_w[g]), .valid_o(div_valid[g])
    );
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
    assign reg_cnt_o[g*CNT_W +: CNT_W]   = cnt_q[g];
    assign reg_ratio_o[g*RAT_W +: RAT_W] = ratio_w[g];
  end

  assign agg_cnt_o     = cnt_q[NUM_REGS];
  assign agg_ratio_o   = ratio_w[NUM_REGS];
  assign ratio_valid_o = &div_valid;
endmodule

// File: rtl/gom_checker.sv
module gom_checker import gom_pkg::*; #(
  parameter int NUM_REGS = 4,
  parameter int MAX_N    = 65536,
  parameter int FRAC_W   = 8,
  parameter int CNT_W    = 17
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      start_i,
  input logic [CNT_W-1:0]          n_i,
  input logic [NUM_REGS-1:0]       mask_i,
  input logic                      sample_i,
  input logic                      busy_o,
  input logic                      done_o,
  input logic [NUM_REGS*CNT_W-1:0] reg_cnt_o,
  input logic [CNT_W-1:0]          agg_cnt_o,
  input logic [FRAC_W:0]           agg_ratio_o,
  input logic                      ratio_valid_o
);
  logic good_start, taken;
  assign good_start = start_i && count_in_range(32'(n_i), MAX_N);
  assign taken      = busy_o && sample_i && !good_start;

  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    good_start |=> (busy_o && agg_cnt_o == '0 && !ratio_valid_o && !done_o)); // R3
  AST_BAD_N_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !good_start && !busy_o) |=> !busy_o); // R3
  AST_AGG_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken |=> (agg_cnt_o == $past(agg_cnt_o) || agg_cnt_o == $past(agg_cnt_o) + CNT_W'(1))); // R4
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R5
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !good_start) |=> ($stable(agg_cnt_o) && $stable(reg_cnt_o))); // R6
  AST_RATIO_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_valid_o |-> (!busy_o && agg_ratio_o <= (FRAC_W+1)'(1 << FRAC_W))); // R7

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_mem
    AST_AGG_LE_MEMBER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (taken && !mask_i[g]) |=> (agg_cnt_o == $past(agg_cnt_o) ||
        reg_cnt_o[g*CNT_W +: CNT_W] != $past(reg_cnt_o[g*CNT_W +: CNT_W]))); // R2
  end
endmodule

bind gate_opp_monitor gom_checker #(
  .NUM_REGS(NUM_REGS), .MAX_N(MAX_N), .FRAC_W(FRAC_W), .CNT_W(CNT_W)
) u_gom_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .n_i(n_i),
  .mask_i(mask_i), .sample_i(sample_i), .busy_o(busy_o), .done_o(done_o),
  .reg_cnt_o(reg_cnt_o), .agg_cnt_o(agg_cnt_o), .agg_ratio_o(agg_ratio_o),
  .ratio_valid_o(ratio_valid_o)
);

// File: tb/gate_opp_monitor_test.sv
`timescale 1ns/1ps
module gate_opp_monitor_test;
  localparam int NR = 4, DW = 8, MAXN = 65536, FW = 8, CW = 17, RW = FW + 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic               rst_ni, start_i, sample_i;
  logic [CW-1:0]      n_i;
  logic [NR-1:0]      mask_i;
  logic [NR*DW-1:0]   d_i, q_i;
  logic               busy_o, done_o, ratio_valid_o;
  logic [NR*CW-1:0]   reg_cnt_o;
  logic [CW-1:0]      agg_cnt_o;
  logic [NR*RW-1:0]   reg_ratio_o;
  logic [RW-1:0]      agg_ratio_o;

  gate_opp_monitor #(.NUM_REGS(NR), .DATA_W(DW), .MAX_N(MAXN), .FRAC_W(FW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .n_i(n_i), .mask_i(mask_i),
    .sample_i(sample_i), .d_i(d_i), .q_i(q_i), .busy_o(busy_o), .done_o(done_o),
    .reg_cnt_o(reg_cnt_o), .agg_cnt_o(agg_cnt_o), .reg_ratio_o(reg_ratio_o),
    .agg_ratio_o(agg_ratio_o), .ratio_valid_o(ratio_valid_o)
  );

  int checks = 0, errors = 0;
  longint exp_reg[NR];
  longint exp_agg;
  logic [NR-1:0] cur_eq;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint ratio_of(input longint c, input longint n);
    return (c << FW) / n;
  endfunction

  function automatic longint reg_cnt(input int r);
    return longint'(reg_cnt_o[r*CW +: CW]);
  endfunction

  task automatic drive_random(input int p_eq);
    for (int r = 0; r < NR; r++) begin
      logic [DW-1:0] dv;
      dv = DW'($urandom);
      d_i[r*DW +: DW] = dv;
      if (int'($urandom % 100) < p_eq) begin
        q_i[r*DW +: DW] = dv;
        cur_eq[r] = 1'b1;
      end else begin
        q_i[r*DW +: DW] = dv ^ DW'(1 << ($urandom % DW));
        cur_eq[r] = 1'b0;
      end
    end
  endtask

  task automatic run_window(input int n, input int p_eq, input logic [NR-1:0] msk,
                            input int p_smp, input int abort_after);
    int acc;
    bit early;
    int t;
    @(negedge clk);
    start_i = 1'b1; n_i = CW'(n); sample_i = 1'b1; mask_i = msk; drive_random(p_eq);
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R3", "busy after start", longint'(busy_o), 1);
    check(agg_cnt_o == '0 && ratio_valid_o == 1'b0, "R3", "cleared, start-cycle sample dropped",
          longint'(agg_cnt_o), 0);
    for (int r = 0; r < NR; r++) exp_reg[r] = 0;
    exp_agg = 0; acc = 0; early = 0;
    while (acc < n && !(abort_after > 0 && acc >= abort_after)) begin
      if (done_o) early = 1;
      sample_i = (int'($urandom % 100) < p_smp);
      mask_i = msk;
      drive_random(p_eq);
      if (sample_i) begin
        acc++;
        for (int r = 0; r < NR; r++) exp_reg[r] += longint'(cur_eq[r]);
        exp_agg += longint'(&(cur_eq | msk));
      end
      @(negedge clk);
    end
    if (abort_after > 0 && acc < n) begin
      sample_i = 1'b0;
      return;
    end
    check(!early, "R5", "no done before last sample", longint'(early), 0);
    check(done_o == 1'b1, "R5", "done after Nth sample", longint'(done_o), 1);
    check(busy_o == 1'b0, "R4", "busy drops after N samples", longint'(busy_o), 0);
    for (int r = 0; r < NR; r++)
      check(reg_cnt(r) == exp_reg[r], "R1", $sformatf("reg %0d count", r), reg_cnt(r), exp_reg[r]);
    check(longint'(agg_cnt_o) == exp_agg, "R2", "aggregate count", longint'(agg_cnt_o), exp_agg);
    for (int r = 0; r < NR; r++)
      if (!msk[r])
        check(longint'(agg_cnt_o) <= reg_cnt(r), "R2", $sformatf("agg <= reg %0d", r),
              longint'(agg_cnt_o), reg_cnt(r));
    // strobes after the window must not move anything
    sample_i = 1'b1; drive_random(100);
    @(negedge clk);
    check(done_o == 1'b0, "R5", "done lasts one cycle", longint'(done_o), 0);
    repeat (3) begin drive_random(100); @(negedge clk); end
    sample_i = 1'b0;
    check(longint'(agg_cnt_o) == exp_agg && reg_cnt(0) == exp_reg[0], "R6", "counts held",
          longint'(agg_cnt_o), exp_agg);
    t = 0;
    while (!ratio_valid_o && t < 200) begin @(negedge clk); t++; end
    check(ratio_valid_o == 1'b1, "R7", "ratio valid", longint'(ratio_valid_o), 1);
    for (int r = 0; r < NR; r++)
      check(longint'(reg_ratio_o[r*RW +: RW]) == ratio_of(exp_reg[r], n), "R7",
            $sformatf("reg %0d ratio", r), longint'(reg_ratio_o[r*RW +: RW]), ratio_of(exp_reg[r], n));
    check(longint'(agg_ratio_o) == ratio_of(exp_agg, n), "R7", "aggregate ratio",
          longint'(agg_ratio_o), ratio_of(exp_agg, n));
  endtask

  task automatic bad_start(input int n);
    longint held;
    held = longint'(agg_cnt_o);
    @(negedge clk);
    start_i = 1'b1; n_i = CW'(n); sample_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; sample_i = 1'b0;
    check(busy_o == 1'b0, "R3", $sformatf("start with n=%0d ignored", n), longint'(busy_o), 0);
    check(ratio_valid_o == 1'b1 && longint'(agg_cnt_o) == held, "R3", "results kept after bad start",
          longint'(agg_cnt_o), held);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 190000) begin @(posedge clk); cyc++; end
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_ni = 1'b0; start_i = 1'b0; sample_i = 1'b0; n_i = '0; mask_i = '0; d_i = '0; q_i = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(!busy_o && !done_o && !ratio_valid_o && agg_cnt_o == '0 && reg_cnt_o == '0, "R4",
          "reset state", longint'(busy_o), 0);

    run_window(1, 50, '0, 100, 0);                        // smallest window
    for (int i = 0; i < 6; i++)
      run_window(1 + int'($urandom % 300), 30 + int'($urandom % 70),
                 NR'($urandom), 30 + int'($urandom % 71), 0);
    run_window(40, 0, '1, 70, 0);                          // R2: fully masked, agg = N
    run_window(50, 60, '0, 80, 10);                        // R8: abandoned mid-window
    run_window(20, 60, '0, 80, 0);                         // R8: restart result only
    bad_start(0);
    bad_start(MAXN + 1);
    run_window(MAXN, 100, '0, 100, 0);                     // largest window, ratio 256

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule